// File: doc/BRIEF.md
# I2C Master FIFO Status and Interrupt Register

This block sits between a CPU register port and the byte engine of a small I2C master. It holds one 4-entry byte FIFO that is shared by both transfer directions. In transmit mode the CPU pushes bytes and the bus engine pulls them. In receive mode the bus engine pushes bytes and the CPU pops them. Switching the direction empties the FIFO, so its contents always belong to the mode that is active.

A single status byte gathers a busy indication, the fill level of the FIFO, a receive-data flag, and four sticky event flags: transmit-empty, no-acknowledge, simultaneous-access error and write-while-full error. Software clears a sticky flag by writing 0 to its bit. An interrupt line combines three of the flags, each through its own enable. A one-cycle abort pulse tells the engine to stop after a missing acknowledge.

Top module: `i2c_fifo_stat`

## Requirements
- R1: After reset every status bit other than busy reads 0, the FIFO is empty, and `irq_o` and `abort_o` are 0.
- R2: Status byte layout: bit 0 busy, bit 1 no-ack, bit 2 receive-data, bit 3 transmit-empty, bits 5:4 fill code, bit 6 access error, bit 7 write-while-full error. Busy follows `eng_busy_i` in the same cycle, and register writes do not change it.
- R3: The fill code is 00 when the FIFO is empty, 10 when it holds 1 to 3 bytes and 11 when it holds 4 bytes. It reports the FIFO of the current mode and never reads 01.
- R4: In transmit mode (`dir_rx_i`=0), a `cpu_wr_i` strobe with `cpu_rd_i` low stores a byte, `eng_pop_i` removes the head, and `tx_data_o` shows the bytes in the order they were written. A push and a pop may happen in the same cycle.
- R5: In receive mode (`dir_rx_i`=1), `eng_push_i` stores `eng_rdata_i` unless the FIFO is full, and `cpu_rd_i` with `cpu_wr_i` low removes the head, which is shown on `rx_data_o`. CPU writes have no effect. The receive-data bit reads 1 exactly while the receive FIFO is not empty.
- R6: The transmit-empty flag is set when the transmit FIFO goes from non-empty to empty, whether by engine pops or by a flush. The flag is sticky.
- R7: `eng_nack_i` sets the no-ack flag on the next edge, and `abort_o` pulses high for the one cycle after the event.
- R8: `cpu_wr_i` and `cpu_rd_i` asserted in the same cycle set the access-error flag, and neither the CPU write nor the CPU read takes effect.
- R9: A CPU write in transmit mode while the FIFO holds 4 bytes sets the write-while-full flag, and the byte is discarded.
- R10: A status write clears each sticky flag (bits 1, 3, 6, 7) whose written bit is 0 and leaves it unchanged where the bit is 1. A set event in the same cycle wins over the clear.
- R11: `flush_i` empties the FIFO in one cycle, and the fill code reads 00 on the next cycle.
- R12: A change of `dir_rx_i` empties the FIFO at the next edge, ignores FIFO strobes in that cycle, and does not set transmit-empty.
- R13: `irq_o` is the OR of receive-data gated by `ien_i[0]`, transmit-empty gated by `ien_i[1]` and no-ack gated by `ien_i[2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_rx_i | input | 1 | Transfer direction, 1 = receive |
| flush_i | input | 1 | Empty the FIFO |
| ien_i | input | 3 | Interrupt enables: receive, transmit-empty, no-ack |
| reg_wr_i | input | 1 | Status register write strobe |
| reg_wdata_i | input | 8 | Status write data (0 clears a sticky bit) |
| reg_rdata_o | output | 8 | Status byte |
| cpu_wr_i | input | 1 | CPU data write strobe |
| cpu_wdata_i | input | 8 | CPU data byte |
| cpu_rd_i | input | 1 | CPU data read strobe |
| rx_data_o | output | 8 | Head byte for the CPU |
| eng_busy_i | input | 1 | Bus transfer in progress |
| eng_nack_i | input | 1 | Slave did not acknowledge (pulse) |
| eng_pop_i | input | 1 | Engine takes a transmit byte |
| tx_data_o | output | 8 | Head byte for the engine |
| eng_push_i | input | 1 | Engine delivers a received byte |
| eng_rdata_i | input | 8 | Received byte |
| abort_o | output | 1 | Stop-transfer pulse after no-ack |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest states to reach are the full transmit FIFO while the engine stays idle, and the cycles in which a set event and a write-zero clear meet on the same flag. The stimulus fills the FIFO with the engine held off and then writes a fifth byte. It issues a no-ack in the same cycle as a clearing write. It changes direction while bytes are still stored, so the bench can confirm the FIFO empties without a transmit-empty event. A behavioural queue model is compared against every output on every cycle.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

  // status byte bit positions
  localparam int unsigned ST_BUSY = 0;
  localparam int unsigned ST_NACK = 1;
  localparam int unsigned ST_RXF  = 2;
  localparam int unsigned ST_TXE  = 3;
  localparam int unsigned ST_FILL = 4;
  localparam int unsigned ST_ACC  = 6;
  localparam int unsigned ST_WRE  = 7;

  // sticky flag vector indices
  localparam int unsigned FL_NACK = 0;
  localparam int unsigned FL_TXE  = 1;
  localparam int unsigned FL_ACC  = 2;
  localparam int unsigned FL_WRE  = 3;
  localparam int unsigned NFLAG   = 4;

  typedef enum logic [1:0] {
    FILL_EMPTY = 2'b00,
    FILL_RSVD  = 2'b01,
    FILL_HALF  = 2'b10,
    FILL_FULL  = 2'b11
  } fill_code_e;

  function automatic fill_code_e fill_code(input int unsigned cnt, input int unsigned depth);
    if (cnt == 0)          return FILL_EMPTY;
    else if (cnt >= depth) return FILL_FULL;
    else                   return FILL_HALF;
  endfunction

  function automatic int unsigned next_count(input int unsigned cnt, input logic push,
                                             input logic pop, input logic clr);
    int unsigned n;
    if (clr) return 0;
    n = cnt;
    if (push) n = n + 1;
    if (pop)  n = n - 1;
    return n;
  endfunction

endpackage

// File: rtl/i2c_byte_fifo.sv
module i2c_byte_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_i && !clr_i) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_i)  rd_ptr <= ptr_inc(rd_ptr);
      cnt_q <= CW'(i2c_stat_pkg::next_count(int'(cnt_q), push_i, pop_i, 1'b0));
    end
  end

  assign dout_o  = mem[rd_ptr];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CW'(DEPTH));

  // R11
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> empty_o);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !pop_i) |-> !push_i);

endmodule

// File: rtl/i2c_access_ctrl.sv
module i2c_access_ctrl #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_i,
  input  logic          flush_i,
  input  logic          cpu_wr_i,
  input  logic          cpu_rd_i,
  input  logic          eng_push_i,
  input  logic          eng_pop_i,
  input  logic [CW-1:0] count_i,
  output logic          dir_q_o,
  output logic          dir_chg_o,
  output logic          clr_o,
  output logic          push_o,
  output logic          pop_o,
  output logic          acc_evt_o,
  output logic          wre_evt_o,
  output logic          txe_evt_o
);

  logic dir_q;
  logic full, empty, wr_ok, rd_ok;
  int unsigned cnt_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) dir_q <= 1'b0;
    else        dir_q <= dir_i;
  end

  assign full      = (count_i == CW'(DEPTH));
  assign empty     = (count_i == '0);
  assign dir_chg_o = dir_i ^ dir_q;
  assign clr_o     = flush_i | dir_chg_o;

  assign acc_evt_o = cpu_wr_i & cpu_rd_i;
  assign wr_ok     = cpu_wr_i & ~cpu_rd_i & ~dir_i;
  assign rd_ok     = cpu_rd_i & ~cpu_wr_i & dir_i;
  assign wre_evt_o = wr_ok & full;

  assign push_o = ~clr_o & ~full & ((wr_ok) | (dir_i & eng_push_i));
  assign pop_o  = ~clr_o & ~empty & ((~dir_i & eng_pop_i) | rd_ok);

  assign cnt_nxt   = i2c_stat_pkg::next_count(int'(count_i), push_o, pop_o, clr_o);
  assign txe_evt_o = ~dir_i & ~dir_chg_o & ~empty & (cnt_nxt == 0);
  assign dir_q_o   = dir_q;

  // R5
  rx_no_cpu_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_i && !eng_push_i) |-> !push_o);

  // R12
  dir_no_txe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_chg_o |-> !txe_evt_o);

endmodule

// File: rtl/i2c_flag_bank.sv
module i2c_flag_bank #(
  parameter int unsigned NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_i,
  input  logic          wr_i,
  input  logic [NF-1:0] wbit_i,
  output logic [NF-1:0] flags_o
);

  for (genvar i = 0; i < NF; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)                    q <= 1'b0;
      else if (set_i[i])             q <= 1'b1;
      else if (wr_i && !wbit_i[i])   q <= 1'b0;
    end
    assign flags_o[i] = q;

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flags_o[i]);

    // R10
    wzero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !wbit_i[i] && !set_i[i]) |=> !flags_o[i]);

    // R10
    wone_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i[i] && !(wr_i && !wbit_i[i])) |=> $stable(flags_o[i]));
  end

endmodule

// File: rtl/i2c_fifo_stat.sv
module i2c_fifo_stat #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_rx_i,
  input  logic          flush_i,
  input  logic [2:0]    ien_i,
  input  logic          reg_wr_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  input  logic          cpu_wr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  input  logic          cpu_rd_i,
  output logic [DW-1:0] rx_data_o,
  input  logic          eng_busy_i,
  input  logic          eng_nack_i,
  input  logic          eng_pop_i,
  output logic [DW-1:0] tx_data_o,
  input  logic          eng_push_i,
  input  logic [DW-1:0] eng_rdata_i,
  output logic          abort_o,
  output logic          irq_o
);
  import i2c_stat_pkg::*;

  logic          dir_q, dir_chg, clr, push, pop;
  logic          acc_evt, wre_evt, txe_evt;
  logic [CW-1:0] count;
  logic          full, empty;
  logic [DW-1:0] fifo_din, fifo_dout;
  logic [NFLAG-1:0] flag_set, flag_wbit, flags;
  logic          rx_ready, abort_q;
  fill_code_e    fill;
  logic          unused_wbits;

  i2c_access_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .dir_i(dir_rx_i), .flush_i(flush_i),
    .cpu_wr_i(cpu_wr_i), .cpu_rd_i(cpu_rd_i),
    .eng_push_i(eng_push_i), .eng_pop_i(eng_pop_i), .count_i(count),
    .dir_q_o(dir_q), .dir_chg_o(dir_chg), .clr_o(clr), .push_o(push), .pop_o(pop),
    .acc_evt_o(acc_evt), .wre_evt_o(wre_evt), .txe_evt_o(txe_evt)
  );

  assign fifo_din = dir_rx_i ? eng_rdata_i : cpu_wdata_i;

  i2c_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .push_i(push), .pop_i(pop),
    .din_i(fifo_din), .dout_o(fifo_dout), .count_o(count),
    .full_o(full), .empty_o(empty)
  );

  assign flag_set[FL_NACK]  = eng_nack_i;
  assign flag_set[FL_TXE]   = txe_evt;
  assign flag_set[FL_ACC]   = acc_evt;
  assign flag_set[FL_WRE]   = wre_evt;
  assign flag_wbit[FL_NACK] = reg_wdata_i[ST_NACK];
  assign flag_wbit[FL_TXE]  = reg_wdata_i[ST_TXE];
  assign flag_wbit[FL_ACC]  = reg_wdata_i[ST_ACC];
  assign flag_wbit[FL_WRE]  = reg_wdata_i[ST_WRE];
  assign unused_wbits = ^{reg_wdata_i[ST_FILL+1], reg_wdata_i[ST_FILL],
                          reg_wdata_i[ST_RXF], reg_wdata_i[ST_BUSY], full};

  i2c_flag_bank #(.NF(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(flag_set), .wr_i(reg_wr_i),
    .wbit_i(flag_wbit), .flags_o(flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) abort_q <= 1'b0;
    else        abort_q <= eng_nack_i;
  end

  assign rx_ready = dir_q & ~empty;
  assign fill     = fill_code(int'(count), DEPTH);

  always_comb begin
    reg_rdata_o                       = '0;
    reg_rdata_o[ST_BUSY]              = eng_busy_i;
    reg_rdata_o[ST_NACK]              = flags[FL_NACK];
    reg_rdata_o[ST_RXF]               = rx_ready;
    reg_rdata_o[ST_TXE]               = flags[FL_TXE];
    reg_rdata_o[ST_FILL+1:ST_FILL]    = fill;
    reg_rdata_o[ST_ACC]               = flags[FL_ACC];
    reg_rdata_o[ST_WRE]               = flags[FL_WRE];
  end

  assign rx_data_o = fifo_dout;
  assign tx_data_o = fifo_dout;
  assign abort_o   = abort_q;
  assign irq_o     = (ien_i[0] & rx_ready) | (ien_i[1] & flags[FL_TXE]) |
                     (ien_i[2] & flags[FL_NACK]);

  // R3
  fill_not_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[ST_FILL+1:ST_FILL] != FILL_RSVD);

  // R7
  nack_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_nack_i |=> (abort_o && reg_rdata_o[ST_NACK]));

  // R8
  acc_noeffect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && !eng_pop_i && !eng_push_i && !clr) |=> $stable(count));

  // R9
  wre_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wre_evt && !eng_pop_i && !clr) |=> (count == CW'(DEPTH)));

  // R12
  dir_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_chg |=> (count == '0));

endmodule

// File: tb/i2c_fifo_stat_tb.sv
module i2c_fifo_stat_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_rx = 1'b0, flush = 1'b0;
  logic [2:0] ien = 3'b000;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'hFF, reg_rdata;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = 8'h00, rx_data, tx_data, eng_rdata = 8'h00;
  logic eng_busy = 1'b0, eng_nack = 1'b0, eng_pop = 1'b0, eng_push = 1'b0;
  logic abort, irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_fifo_stat u_dut (
    .clk(clk), .rst_n(rst_n), .dir_rx_i(dir_rx), .flush_i(flush), .ien_i(ien),
    .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .cpu_wr_i(cpu_wr), .cpu_wdata_i(cpu_wdata), .cpu_rd_i(cpu_rd), .rx_data_o(rx_data),
    .eng_busy_i(eng_busy), .eng_nack_i(eng_nack), .eng_pop_i(eng_pop), .tx_data_o(tx_data),
    .eng_push_i(eng_push), .eng_rdata_i(eng_rdata), .abort_o(abort), .irq_o(irq)
  );

  int checks = 0, errors = 0, cycles = 0;

  // reference model state
  logic [7:0] q[$];
  bit m_dir = 0, m_nack = 0, m_txe = 0, m_acc = 0, m_wre = 0, m_abort = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
    end
  endtask

  function automatic int fill_of(input int n);
    if (n == 0) return 0;
    if (n >= 4) return 3;
    return 2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_dir = 0; m_nack = 0; m_txe = 0; m_acc = 0; m_wre = 0; m_abort = 0;
    end else begin
      int old_n;
      bit chg, clear, cw, cr, was_full, txe_e, wclr;
      old_n = q.size();
      chg = (dir_rx != m_dir);
      clear = flush || chg;
      was_full = (old_n == 4);
      cw = cpu_wr && !cpu_rd;
      cr = cpu_rd && !cpu_wr;
      if (clear) q.delete();
      else if (!dir_rx) begin
        if (eng_pop && old_n > 0) void'(q.pop_front());
        if (cw && !was_full) q.push_back(cpu_wdata);
      end else begin
        if (cr && old_n > 0) void'(q.pop_front());
        if (eng_push && !was_full) q.push_back(eng_rdata);
      end
      txe_e = !dir_rx && !chg && old_n != 0 && q.size() == 0;
      wclr = reg_wr;
      m_nack = eng_nack || (m_nack && !(wclr && !reg_wdata[1]));
      m_txe  = txe_e    || (m_txe  && !(wclr && !reg_wdata[3]));
      m_acc  = (cpu_wr && cpu_rd) || (m_acc && !(wclr && !reg_wdata[6]));
      m_wre  = (cw && !dir_rx && was_full) || (m_wre && !(wclr && !reg_wdata[7]));
      m_abort = eng_nack;
      m_dir = dir_rx;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL R1 watchdog expired: actual %0d expected below 20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rst_n) begin
      bit rxf;
      rxf = m_dir && q.size() > 0;
      check(reg_rdata[0] === eng_busy, "R2 busy", reg_rdata[0], eng_busy);
      check(reg_rdata[1] === m_nack, "R7 nack", reg_rdata[1], m_nack);
      check(reg_rdata[2] === rxf, "R5 rx-ready", reg_rdata[2], rxf);
      check(reg_rdata[3] === m_txe, "R6 tx-empty", reg_rdata[3], m_txe);
      check(int'(reg_rdata[5:4]) == fill_of(q.size()), "R3 fill", reg_rdata[5:4], fill_of(q.size()));
      check(reg_rdata[6] === m_acc, "R8 access error", reg_rdata[6], m_acc);
      check(reg_rdata[7] === m_wre, "R9 write error", reg_rdata[7], m_wre);
      check(abort === m_abort, "R7 abort", abort, m_abort);
      check(irq === ((ien[0] && rxf) || (ien[1] && m_txe) || (ien[2] && m_nack)),
            "R13 irq", irq, (ien[0] && rxf) || (ien[1] && m_txe) || (ien[2] && m_nack));
      if (q.size() > 0 && m_dir)  check(rx_data === q[0], "R5 rx data", rx_data, q[0]);
      if (q.size() > 0 && !m_dir) check(tx_data === q[0], "R4 tx data", tx_data, q[0]);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    cpu_wr = 0; cpu_rd = 0; eng_pop = 0; eng_push = 0; eng_nack = 0;
    flush = 0; reg_wr = 0; reg_wdata = 8'hFF;
  endtask

  task automatic cpu_write(input logic [7:0] b);
    cpu_wr = 1; cpu_wdata = b; tick();
  endtask

  task automatic eng_give(input logic [7:0] b);
    eng_push = 1; eng_rdata = b; tick();
  endtask

  task automatic reg_write(input logic [7:0] v);
    reg_wr = 1; reg_wdata = v; tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; #1;
    // R1 reset state
    check(reg_rdata == 8'h00, "R1 status after reset", reg_rdata, 0);
    check(irq == 1'b0 && abort == 1'b0, "R1 irq/abort after reset", {irq, abort}, 0);
    ien = 3'b111;
    tick();
    // transmit fill, R4 / R3
    cpu_write(8'hA1); cpu_write(8'hB2); cpu_write(8'hC3); cpu_write(8'hD4);
    check(reg_rdata[5:4] == 2'b11, "R3 full code", reg_rdata[5:4], 3);
    cpu_write(8'hE5);              // R9 write while full
    check(reg_rdata[7] == 1'b1, "R9 set on full write", reg_rdata[7], 1);
    eng_pop = 1; tick();
    check(tx_data == 8'hB2, "R4 order after pop", tx_data, 8'hB2);
    cpu_wr = 1; cpu_wdata = 8'h66; eng_pop = 1; tick();   // simultaneous push and pop
    reg_write(8'hFF);              // R10 write ones: no change
    check(reg_rdata[7] == 1'b1, "R10 write one keeps", reg_rdata[7], 1);
    reg_write(8'h7F);              // R10 clear write error
    check(reg_rdata[7] == 1'b0, "R10 write zero clears", reg_rdata[7], 0);
    repeat (4) begin eng_pop = 1; tick(); end
    check(reg_rdata[3] == 1'b1, "R6 tx empty set", reg_rdata[3], 1);
    ien = 3'b101; tick();
    ien = 3'b111;
    reg_write(8'hF7);
    check(reg_rdata[3] == 1'b0, "R10 tx-empty cleared", reg_rdata[3], 0);
    // R8 access error
    cpu_write(8'h11);
    cpu_wr = 1; cpu_rd = 1; cpu_wdata = 8'h22; tick();
    check(reg_rdata[6] == 1'b1 && reg_rdata[5:4] == 2'b10, "R8 trapped, no push",
          reg_rdata, 8'h60);
    // R7 nack with same-cycle clear: set wins
    eng_busy = 1;
    eng_nack = 1; reg_wr = 1; reg_wdata = 8'h00; tick();
    check(reg_rdata[1] == 1'b1 && abort == 1'b1, "R10 set wins over clear", reg_rdata[1], 1);
    tick();
    check(abort == 1'b0, "R7 abort one cycle", abort, 0);
    eng_busy = 0;
    reg_write(8'h00);
    // R11 flush
    cpu_write(8'h31); cpu_write(8'h32);
    flush = 1; tick();
    check(reg_rdata[5:4] == 2'b00, "R11 flush empties", reg_rdata[5:4], 0);
    check(reg_rdata[3] == 1'b1, "R6 flush sets tx-empty", reg_rdata[3], 1);
    reg_write(8'h00);
    // R12 direction change with stored bytes
    cpu_write(8'h41); cpu_write(8'h42);
    dir_rx = 1; eng_push = 1; eng_rdata = 8'h99; tick();
    check(reg_rdata[5:4] == 2'b00 && reg_rdata[3] == 1'b0, "R12 dir change clears",
          reg_rdata, 0);
    // receive path R5
    eng_give(8'h51); eng_give(8'h52);
    cpu_write(8'hEE);              // ignored in receive mode
    check(reg_rdata[5:4] == 2'b10 && rx_data == 8'h51, "R5 cpu write ignored", rx_data, 8'h51);
    eng_give(8'h53); eng_give(8'h54); eng_give(8'h55);
    check(reg_rdata[5:4] == 2'b11 && reg_rdata[7] == 1'b0, "R5 full, no write error",
          reg_rdata, 8'h34);
    cpu_rd = 1; eng_push = 1; eng_rdata = 8'h56; tick();
    repeat (4) begin cpu_rd = 1; tick(); end
    check(reg_rdata[2] == 1'b0, "R5 rx-ready drops", reg_rdata[2], 0);
    ien = 3'b000; eng_give(8'h61); tick();
    check(irq == 1'b0, "R13 gated off", irq, 0);
    ien = 3'b001; tick();
    check(irq == 1'b1, "R13 rx enable", irq, 1);
    dir_rx = 0; tick(); tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule